// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Bank

This block keeps one 32-bit pending word for each processor of a multiprocessor system, up to sixteen of them. Software reaches the words through a small word-addressed register bus: the processor page is picked by the 4 KB page bits of the address, and inside a page one word reads the pending value while two other words set or clear soft interrupt bits. Soft interrupts occupy the upper part of the word (bits 17 to 31). Hardware sources reach the lower part through a side port that raises or drops a single level bit (bits 1 to 15) of a chosen processor.

For every processor the block continuously encodes the highest soft interrupt present and drives it as a 4-bit level, together with a request line that is held off while that processor reports it is still busy with an earlier interrupt. Request and response on the register bus each use a valid/ready pair. A read answers one cycle after it is accepted, and the answer is held until the requester takes it. While an answer is waiting, no new request is accepted.

Top module: `soft_irq_bank`

## Requirements
- R1: After reset every pending word is zero, every `int_req` bit and `int_level` field is zero, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The processor index is `req_addr[15:12]` and the word select is `req_addr[3:2]`. A taken read of word 0 returns that processor's pending word as it stood at that edge. A taken read of word 1, 2 or 3 returns zero.
- R3: A taken write to word 1 clears, in the addressed pending word, every bit set in `req_wdata & 32'hFFFE0000`. If `req_wdata[14]` is 1, bit 31 is also cleared by the same write.
- R4: A taken write to word 2 sets, in the addressed pending word, every bit set in `req_wdata & 32'hFFFE0000`. Bits 16 to 0 do not change.
- R5: A taken write to word 0 or word 3 changes no pending word.
- R6: The field `int_level[4*i +: 4]` equals j−16, where j is the highest set bit of processor i's pending word in the range 17 to 31. It is 0 when none of these bits is set. Bits 0 to 16 never affect it.
- R7: `int_req[i]` is 1 exactly when processor i's level is non-zero and `int_busy[i]` is 0.
- R8: A cycle with `hw_valid` high sets bit `hw_level` of pending word `hw_cpu` to 1 when `hw_set` is 1, and to 0 when `hw_set` is 0. A `hw_level` of 0 changes nothing.
- R9: A register write and a side-port event in the same cycle both take effect at that edge, including when they address the same processor.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, `rsp_data` stays unchanged and `req_ready` is low. `rsp_valid` drops on the edge where `rsp_ready` is seen high, unless a new read is taken at that same edge.
- R11: Every change to a pending word is visible at the ports from the clock edge that takes the request. Only the addressed processor's word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Byte address: page bits select the processor, bits 3:2 select the word |
| req_wdata | input | 32 | Write value |
| rsp_valid | output | 1 | Read answer present |
| rsp_ready | input | 1 | Requester takes the read answer |
| rsp_data | output | 32 | Read answer |
| hw_valid | input | 1 | Side-port event in this cycle |
| hw_set | input | 1 | 1 raises the level bit, 0 drops it |
| hw_cpu | input | 4 | Processor addressed by the side port |
| hw_level | input | 4 | Bit index raised or dropped; 0 is ignored |
| int_busy | input | 16 | Per processor: an interrupt is still outstanding |
| int_req | output | 16 | Per processor interrupt request |
| int_level | output | 64 | Per processor soft interrupt level, 4 bits each |

## Verification
The properties assume that `req_valid` and `req_write` are known whenever they are sampled, and that only one side-port event arrives per cycle. They also assume the side port never names bit positions 17 and above, which holds because its level is only 4 bits wide. The write properties rely on software and the side port touching disjoint bit ranges, so a side event in the same cycle cannot mask a software result. The bench follows these assumptions: it changes inputs only on falling edges, drives at most one side event per cycle, and places its one deliberate collision on the same processor in different bit ranges.

// File: rtl/soft_irq_pkg.sv
package soft_irq_pkg;

  localparam int WORD_W     = 32;
  localparam int SOFT_LSB   = 17;   // lowest soft interrupt bit
  localparam int LEVEL_BIAS = 16;   // level = bit index - bias
  localparam int CPU_LSB    = 12;   // page index position in the address
  localparam int WSEL_LSB   = 2;    // word select position in the address
  localparam int WSEL_W     = 2;
  localparam int ALIAS_SRC  = 14;   // clear-write bit that also hits the top bit
  localparam int ALIAS_DST  = 31;

  localparam logic [WORD_W-1:0] SOFT_MASK = ~((32'd1 << SOFT_LSB) - 32'd1);

  typedef enum logic [WSEL_W-1:0] {
    WSEL_PEND = 2'd0,
    WSEL_CLR  = 2'd1,
    WSEL_SET  = 2'd2,
    WSEL_RSV  = 2'd3
  } wsel_e;

  function automatic logic [WORD_W-1:0] clr_bits(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] m;
    m = v & SOFT_MASK;
    if (v[ALIAS_SRC]) m[ALIAS_DST] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] set_bits(input logic [WORD_W-1:0] v);
    return v & SOFT_MASK;
  endfunction

endpackage

// File: rtl/soft_irq_prio.sv
module soft_irq_prio
  import soft_irq_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [LVL_W-1:0]  level_o
);

  // Highest set soft bit wins; later loop iterations overwrite earlier ones.
  always_comb begin
    level_o = '0;
    for (int j = SOFT_LSB; j < WORD_W; j++) begin
      if (word_i[j]) level_o = LVL_W'(j - LEVEL_BIAS);
    end
  end

endmodule

// File: rtl/soft_irq_slot.sv
module soft_irq_slot
  import soft_irq_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] sw_clr_i,
  input  logic [WORD_W-1:0] sw_set_i,
  input  logic              hw_hit_i,
  input  logic              hw_set_i,
  input  logic [LVL_W-1:0]  hw_level_i,
  output logic [WORD_W-1:0] pend_o,
  output logic [LVL_W-1:0]  level_o
);

  logic [WORD_W-1:0] pend_q;
  logic [WORD_W-1:0] pend_d;

  // Software first, then the side port; the two touch disjoint bit ranges.
  always_comb begin
    pend_d = (pend_q & ~sw_clr_i) | sw_set_i;
    if (hw_hit_i && (hw_level_i != '0)) begin
      pend_d[hw_level_i] = hw_set_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  soft_irq_prio #(.LVL_W(LVL_W)) u_prio (
    .word_i  (pend_q),
    .level_o (level_o)
  );

  assign pend_o = pend_q;

endmodule

// File: rtl/soft_irq_bus_port.sv
module soft_irq_bus_port
  import soft_irq_pkg::*;
#(
  parameter int NUM_CPU = 16,
  parameter int ADDR_W  = 16,
  parameter int CPU_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_write,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [WORD_W-1:0]              req_wdata,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [WORD_W-1:0]              rsp_data,
  input  logic [NUM_CPU-1:0][WORD_W-1:0] pend_i,
  output logic [NUM_CPU-1:0][WORD_W-1:0] clr_o,
  output logic [NUM_CPU-1:0][WORD_W-1:0] set_o
);

  logic              take;
  logic [CPU_W-1:0]  cpu_idx;
  wsel_e             wsel;
  logic [WORD_W-1:0] clr_val;
  logic [WORD_W-1:0] set_val;
  logic [WORD_W-1:0] rd_word;
  logic              addr_unused;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;

  assign addr_unused = ^req_addr;
  assign cpu_idx     = req_addr[CPU_LSB +: CPU_W];
  assign wsel        = wsel_e'(req_addr[WSEL_LSB +: WSEL_W]);

  // A waiting answer blocks every new request.
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign take      = req_valid && req_ready;

  assign clr_val = clr_bits(req_wdata);
  assign set_val = set_bits(req_wdata);

  generate
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_sel
      logic hit;
      assign hit = take && req_write && (cpu_idx == CPU_W'(i));
      assign clr_o[i] = (hit && wsel == WSEL_CLR) ? clr_val : '0;
      assign set_o[i] = (hit && wsel == WSEL_SET) ? set_val : '0;
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (cpu_idx == CPU_W'(i) && wsel == WSEL_PEND) rd_word = pend_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (take && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/soft_irq_bank.sv
module soft_irq_bank
  import soft_irq_pkg::*;
#(
  parameter int NUM_CPU = 16,
  parameter int ADDR_W  = 16,
  parameter int LVL_W   = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [WORD_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [WORD_W-1:0]        rsp_data,
  input  logic                     hw_valid,
  input  logic                     hw_set,
  input  logic [CPU_W-1:0]         hw_cpu,
  input  logic [LVL_W-1:0]         hw_level,
  input  logic [NUM_CPU-1:0]       int_busy,
  output logic [NUM_CPU-1:0]       int_req,
  output logic [NUM_CPU*LVL_W-1:0] int_level
);

  logic [NUM_CPU-1:0][WORD_W-1:0] pend;
  logic [NUM_CPU-1:0][WORD_W-1:0] sw_clr;
  logic [NUM_CPU-1:0][WORD_W-1:0] sw_set;

  soft_irq_bus_port #(
    .NUM_CPU (NUM_CPU),
    .ADDR_W  (ADDR_W),
    .CPU_W   (CPU_W)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .pend_i    (pend),
    .clr_o     (sw_clr),
    .set_o     (sw_set)
  );

  generate
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
      logic [LVL_W-1:0] lvl;
      logic             hw_hit;
      assign hw_hit = hw_valid && (hw_cpu == CPU_W'(i));

      soft_irq_slot #(.LVL_W(LVL_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_clr_i   (sw_clr[i]),
        .sw_set_i   (sw_set[i]),
        .hw_hit_i   (hw_hit),
        .hw_set_i   (hw_set),
        .hw_level_i (hw_level),
        .pend_o     (pend[i]),
        .level_o    (lvl)
      );

      assign int_level[i*LVL_W +: LVL_W] = lvl;
      assign int_req[i] = (lvl != '0) && !int_busy[i];
    end
  endgenerate

endmodule

// File: rtl/soft_irq_bank_chk.sv
module soft_irq_bank_chk
  import soft_irq_pkg::*;
#(
  parameter int NUM_CPU = 16,
  parameter int ADDR_W  = 16,
  parameter int LVL_W   = 4,
  parameter int CPU_W   = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid,
  input logic                           req_ready,
  input logic                           req_write,
  input logic [ADDR_W-1:0]              req_addr,
  input logic [WORD_W-1:0]              req_wdata,
  input logic                           rsp_valid,
  input logic                           rsp_ready,
  input logic [WORD_W-1:0]              rsp_data,
  input logic                           hw_valid,
  input logic                           hw_set,
  input logic [CPU_W-1:0]               hw_cpu,
  input logic [LVL_W-1:0]               hw_level,
  input logic [NUM_CPU-1:0]             int_busy,
  input logic [NUM_CPU-1:0]             int_req,
  input logic [NUM_CPU*LVL_W-1:0]       int_level,
  input logic [NUM_CPU-1:0][WORD_W-1:0] pend
);

  logic              acc_wr;
  logic              acc_rd;
  logic [CPU_W-1:0]  a_cpu;
  logic [1:0]        a_word;
  logic [WORD_W-1:0] a_set;
  logic [WORD_W-1:0] a_clr;

  assign acc_wr = req_valid && req_ready && req_write;
  assign acc_rd = req_valid && req_ready && !req_write;
  assign a_cpu  = req_addr[CPU_LSB +: CPU_W];
  assign a_word = req_addr[WSEL_LSB +: WSEL_W];
  assign a_set  = req_wdata & 32'hFFFE0000;
  assign a_clr  = (req_wdata & 32'hFFFE0000) | (req_wdata[14] ? 32'h80000000 : 32'h0);

  assert_hold_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_block_while_waiting_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_answer_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(acc_rd));

  assert_set_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && a_word == 2'd2) |=>
      ((pend[$past(a_cpu)] & $past(a_set)) == $past(a_set)));

  assert_clear_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && a_word == 2'd1) |=> ((pend[$past(a_cpu)] & $past(a_clr)) == '0));

  assert_dead_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && (a_word == 2'd0 || a_word == 2'd3) && !hw_valid) |=> $stable(pend));

  assert_side_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && hw_level != '0) |=> (pend[$past(hw_cpu)][$past(hw_level)] == $past(hw_set)));

  generate
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu_chk
      assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_req[i] |-> !int_busy[i]);
      assert_req_has_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_req[i] |-> (int_level[i*LVL_W +: LVL_W] != '0));
      assert_level_tracks_soft_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[i][WORD_W-1:SOFT_LSB] == '0) |-> (int_level[i*LVL_W +: LVL_W] == '0));
    end
  endgenerate

endmodule

bind soft_irq_bank soft_irq_bank_chk #(
  .NUM_CPU (NUM_CPU),
  .ADDR_W  (ADDR_W),
  .LVL_W   (LVL_W),
  .CPU_W   (CPU_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .hw_valid  (hw_valid),
  .hw_set    (hw_set),
  .hw_cpu    (hw_cpu),
  .hw_level  (hw_level),
  .int_busy  (int_busy),
  .int_req   (int_req),
  .int_level (int_level),
  .pend      (pend)
);

// File: tb/soft_irq_bank_tb.sv
module soft_irq_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        hw_valid = 1'b0;
  logic        hw_set = 1'b0;
  logic [3:0]  hw_cpu = '0;
  logic [3:0]  hw_level = '0;
  logic [15:0] int_busy = '0;
  logic [15:0] int_req;
  logic [63:0] int_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  soft_irq_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .hw_valid  (hw_valid),
    .hw_set    (hw_set),
    .hw_cpu    (hw_cpu),
    .hw_level  (hw_level),
    .int_busy  (int_busy),
    .int_req   (int_req),
    .int_level (int_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int cpu, input int word, input logic [31:0] val);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr  = 16'((cpu << 12) | (word << 2)); req_wdata = val;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input int cpu, input int word, output logic [31:0] val);
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_write = 1'b0;
    req_addr  = 16'((cpu << 12) | (word << 2));
    @(negedge clk);
    req_valid = 1'b0;
    val = rsp_valid ? rsp_data : 32'hDEADDEAD;
  endtask

  task automatic hw_event(input int cpu, input int lvl, input bit set);
    @(negedge clk);
    hw_valid = 1'b1; hw_cpu = 4'(cpu); hw_level = 4'(lvl); hw_set = set;
    @(negedge clk);
    hw_valid = 1'b0;
  endtask

  function automatic logic [31:0] lvl_of(input int cpu);
    return 32'(int_level[cpu*4 +: 4]);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    check("R1 int_req", 32'(int_req), 32'h0);
    check("R1 int_level", int_level[31:0] | int_level[63:32], 32'h0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check("R1 req_ready", 32'(req_ready), 32'h1);
    bus_read(0, 0, v);  check("R1 pend cpu0", v, 32'h0);
    bus_read(15, 0, v); check("R1 pend cpu15", v, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] v;
    bus_write(3, 2, 32'hFFFF_FFFF);
    check("R11 level cpu3 right after edge", lvl_of(3), 32'd15);
    check("R7 req cpu3", 32'(int_req[3]), 32'h1);
    bus_read(3, 0, v); check("R4 set masked", v, 32'hFFFE_0000);
    bus_read(2, 0, v); check("R11 other cpu untouched", v, 32'h0);
    check("R7 req cpu2", 32'(int_req[2]), 32'h0);
  endtask

  task automatic t_other_words();
    logic [31:0] v;
    bus_read(3, 1, v); check("R2 word1 reads zero", v, 32'h0);
    bus_read(3, 2, v); check("R2 word2 reads zero", v, 32'h0);
    bus_read(3, 3, v); check("R2 word3 reads zero", v, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    bus_write(3, 1, 32'h8000_0000);
    bus_read(3, 0, v); check("R3 clear bit31", v, 32'h7FFE_0000);
    check("R6 level after clear", lvl_of(3), 32'd14);
    hw_event(3, 14, 1'b1);
    bus_write(3, 2, 32'h8000_0000);
    bus_write(3, 1, 32'h0000_4000);
    bus_read(3, 0, v); check("R3 bit14 alias clears bit31 only", v, 32'h7FFE_4000);
    bus_write(3, 1, 32'hFFFF_FFFF);
    bus_read(3, 0, v); check("R3 full clear keeps low bits", v, 32'h0000_4000);
    check("R6 low bits give no level", lvl_of(3), 32'd0);
    check("R7 no req", 32'(int_req[3]), 32'h0);
    hw_event(3, 14, 1'b0);
    bus_read(3, 0, v); check("R8 side clear", v, 32'h0);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    bus_write(5, 0, 32'hFFFF_FFFF);
    bus_write(5, 3, 32'hFFFF_FFFF);
    bus_read(5, 0, v); check("R5 dead words", v, 32'h0);
    check("R5 no req", 32'(int_req[5]), 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    bus_write(7, 2, 32'h0006_0000);
    check("R6 level two", lvl_of(7), 32'd2);
    hw_event(7, 5, 1'b1);
    check("R6 low bit no effect", lvl_of(7), 32'd2);
    bus_read(7, 0, v); check("R8 side set cpu7", v, 32'h0006_0020);
    bus_write(7, 1, 32'h0004_0000);
    check("R6 level one", lvl_of(7), 32'd1);
  endtask

  task automatic t_hw();
    logic [31:0] v;
    hw_event(9, 0, 1'b1);
    bus_read(9, 0, v); check("R8 level zero ignored", v, 32'h0);
    hw_event(9, 15, 1'b1);
    bus_read(9, 0, v); check("R8 set bit15", v, 32'h0000_8000);
    check("R6 side bits no level", lvl_of(9), 32'd0);
    hw_event(9, 15, 1'b0);
    bus_read(9, 0, v); check("R8 clear bit15", v, 32'h0);
  endtask

  task automatic t_busy();
    bus_write(3, 2, 32'h0010_0000);
    check("R6 level four", lvl_of(3), 32'd4);
    @(negedge clk); int_busy[3] = 1'b1; #1;
    check("R7 busy holds off", 32'(int_req[3]), 32'h0);
    check("R7 level kept while busy", lvl_of(3), 32'd4);
    @(negedge clk); int_busy[3] = 1'b0; #1;
    check("R7 req after busy", 32'(int_req[3]), 32'h1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h3000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 answer valid", 32'(rsp_valid), 32'h1);
    check("R10 answer data", rsp_data, 32'h0010_0000);
    check("R10 not ready while waiting", 32'(req_ready), 32'h0);
    @(negedge clk);
    check("R10 still valid", 32'(rsp_valid), 32'h1);
    check("R10 data stable", rsp_data, 32'h0010_0000);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 drops after take", 32'(rsp_valid), 32'h0);
    check("R10 ready again", 32'(req_ready), 32'h1);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hB008; req_wdata = 32'h0010_0000;
    hw_valid = 1'b1; hw_cpu = 4'd11; hw_level = 4'd3; hw_set = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; hw_valid = 1'b0;
    bus_read(11, 0, v); check("R9 both apply", v, 32'h0010_0008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set();
    t_other_words();
    t_clear();
    t_ignore();
    t_level();
    t_hw();
    t_busy();
    t_backpressure();
    t_same_cycle();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule